// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a wide set of level-sensitive interrupt request lines and folds them onto a small number of master interrupt outputs. Every 32 sources form a group. Each group has three software-visible words: a mask word that enables sources, a force word that raises sources by software, and a status word that is read-only. Two neighbouring groups, that is 64 consecutive sources, feed one master output. A single master-disable word can silence any master output. A global status bit shows whether anything anywhere is pending, whatever the master-disable word holds.

Software reaches the block through a plain word-addressed port. A write takes effect at the clock edge where it is sampled. A read returns the addressed word one cycle after the address is presented. Word indices inside each bank run in reverse: the highest index holds the lowest-numbered sources. Raw request lines first pass through a synchronizer. A request then needs three clock edges to show up on its master output.

Top module: `irqSteerAgg`

## Requirements
- R1: After reset every mask, force and master-disable word reads 0, all master outputs are 0 and the read data is 0.
- R2: Word addresses: mask words at 0..15, force words at 16..31, status words at 32..47, master-disable at 48 (bits 7:0), global status at 49 (bit 0). Read data shows the word whose address was presented at the previous clock edge. Addresses 50 and above read 0.
- R3: Source n sits in word index 15 - n/32 of each bank, at bit n mod 32.
- R4: A mask bit of 1 enables its source and a mask bit of 0 blocks it. A status bit without force equals source AND mask bit.
- R5: A force bit of 1 sets its status bit even when the mask bit is 0 and the source is low.
- R6: Master output m is the OR of the status bits of sources 64m..64m+63. It is registered. A source change presented before clock edge E1 shows on the output after edge E3, not before.
- R7: Master-disable bit m set to 1 holds master output m at 0 from the second edge after the write. Other master outputs are unaffected.
- R8: Global status bit reads 1 when any status bit is 1, even if all master outputs are disabled.
- R9: Writes to status words, the global status address or unused addresses change no mask, force or master-disable state.
- R10: Mask and force words are written as whole 32-bit words and read back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIrq | input | 512 | Raw level interrupt requests |
| regWr | input | 1 | Write strobe for the addressed word |
| regAddr | input | 6 | Word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, one cycle after the address |
| masterIrq | output | 8 | Aggregated master interrupt outputs |

## Verification
A single request is driven with its mask clear and then set. This separates source gating from pass-through. A request in the middle of the range (source 300) checks the reversed word index and the bit offset at once. A force bit on a masked source checks that forcing bypasses the mask. The master-disable word is then raised while requests are pending; this shows that the outputs drop while the global status bit stays set. A long run toggles random requests across all 512 lines, with all masks open and occasional force writes, and compares every output on every clock against a behavioural model, which exposes errors in grouping, latency and read-mux selection.

// File: rtl/irqSteerPkg.sv
package irqSteerPkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic maskWr;
    logic forceWr;
    logic mdisWr;
  } regStrobe_t;

  typedef enum logic [2:0] {
    BK_NONE,
    BK_MASK,
    BK_FORCE,
    BK_STAT,
    BK_MDIS,
    BK_MSTAT
  } bankSel_t;
endpackage

// File: rtl/irqAggCtl.sv
module irqAggCtl
  import irqSteerPkg::*;
#(
  parameter int NGRP  = 16,
  parameter int NMST  = 8,
  parameter int ADDRW = 6,
  parameter int IDXW  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWr,
  input  logic [ADDRW-1:0]              regAddr,
  input  logic [NGRP-1:0][WORD_W-1:0]   maskWords,
  input  logic [NGRP-1:0][WORD_W-1:0]   forceWords,
  input  logic [NGRP-1:0][WORD_W-1:0]   statusWords,
  input  logic [NMST-1:0]               mdis,
  input  logic                          anyStat,
  output regStrobe_t                    strobe,
  output logic [IDXW-1:0]               wrIdx,
  output logic [WORD_W-1:0]             regRdata
);
  localparam int FORCE_BASE = NGRP;
  localparam int STAT_BASE  = 2 * NGRP;
  localparam int MDIS_ADDR  = 3 * NGRP;
  localparam int MSTAT_ADDR = 3 * NGRP + 1;

  bankSel_t          bank;
  logic [IDXW-1:0]   idx;
  logic [WORD_W-1:0] rdNext;

  always_comb begin
    bank = BK_NONE;
    idx  = '0;
    for (int r = 0; r < NGRP; r++) begin
      if (regAddr == ADDRW'(r)) begin
        bank = BK_MASK;
        idx  = IDXW'(r);
      end
      if (regAddr == ADDRW'(FORCE_BASE + r)) begin
        bank = BK_FORCE;
        idx  = IDXW'(r);
      end
      if (regAddr == ADDRW'(STAT_BASE + r)) begin
        bank = BK_STAT;
        idx  = IDXW'(r);
      end
    end
    if (regAddr == ADDRW'(MDIS_ADDR))  bank = BK_MDIS;
    if (regAddr == ADDRW'(MSTAT_ADDR)) bank = BK_MSTAT;
  end

  always_comb begin
    strobe         = '0;
    strobe.maskWr  = regWr && (bank == BK_MASK);
    strobe.forceWr = regWr && (bank == BK_FORCE);
    strobe.mdisWr  = regWr && (bank == BK_MDIS);
    wrIdx          = idx;
  end

  always_comb begin
    unique case (bank)
      BK_MASK:  rdNext = maskWords[idx];
      BK_FORCE: rdNext = forceWords[idx];
      BK_STAT:  rdNext = statusWords[idx];
      BK_MDIS:  rdNext = WORD_W'(mdis);
      BK_MSTAT: rdNext = WORD_W'(anyStat);
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdata <= '0;
    else       regRdata <= rdNext;
  end
endmodule

// File: rtl/irqAggPath.sv
module irqAggPath
  import irqSteerPkg::*;
#(
  parameter int NUM_SRC     = 512,
  parameter int NMST        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDXW        = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            srcIrq,
  input  regStrobe_t                    strobe,
  input  logic [IDXW-1:0]               wrIdx,
  input  logic [WORD_W-1:0]             wrData,
  output logic [NUM_SRC/WORD_W-1:0][WORD_W-1:0] maskWords,
  output logic [NUM_SRC/WORD_W-1:0][WORD_W-1:0] forceWords,
  output logic [NUM_SRC/WORD_W-1:0][WORD_W-1:0] statusWords,
  output logic [NMST-1:0]               mdis,
  output logic                          anyStat,
  output logic [NMST-1:0]               masterIrq
);
  localparam int NGRP = NUM_SRC / WORD_W;
  localparam int GPM  = NGRP / NMST;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] srcSettled;
  logic [NGRP-1:0]    groupAny;
  logic [NMST-1:0]    masterNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= srcIrq;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign srcSettled = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskWords  <= '0;
      forceWords <= '0;
      mdis       <= '0;
    end else begin
      if (strobe.maskWr)  maskWords[wrIdx]  <= wrData;
      if (strobe.forceWr) forceWords[wrIdx] <= wrData;
      if (strobe.mdisWr)  mdis              <= wrData[NMST-1:0];
    end
  end

  for (genvar r = 0; r < NGRP; r++) begin : g_word
    localparam int GRP = NGRP - 1 - r;
    assign statusWords[r] = (srcSettled[GRP*WORD_W +: WORD_W] & maskWords[r]) | forceWords[r];
    assign groupAny[GRP]  = |statusWords[r];
  end

  for (genvar m = 0; m < NMST; m++) begin : g_master
    assign masterNext[m] = (|groupAny[m*GPM +: GPM]) & ~mdis[m];
  end

  assign anyStat = |groupAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) masterIrq <= '0;
    else       masterIrq <= masterNext;
  end
endmodule

// File: rtl/irqSteerAgg.sv
module irqSteerAgg
  import irqSteerPkg::*;
#(
  parameter int NUM_SRC     = 512,
  parameter int NUM_MASTER  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC-1:0]          srcIrq,
  input  logic                        regWr,
  input  logic [$clog2(3*(NUM_SRC/32)+2)-1:0] regAddr,
  input  logic [31:0]                 regWdata,
  output logic [31:0]                 regRdata,
  output logic [NUM_MASTER-1:0]       masterIrq
);
  localparam int NGRP  = NUM_SRC / WORD_W;
  localparam int ADDRW = $clog2(3 * NGRP + 2);
  localparam int IDXW  = (NGRP > 1) ? $clog2(NGRP) : 1;

  regStrobe_t                  strobe;
  logic [IDXW-1:0]             wrIdx;
  logic [NGRP-1:0][WORD_W-1:0] maskWords;
  logic [NGRP-1:0][WORD_W-1:0] forceWords;
  logic [NGRP-1:0][WORD_W-1:0] statusWords;
  logic [NUM_MASTER-1:0]       mdis;
  logic                        anyStat;

  irqAggCtl #(
    .NGRP (NGRP),
    .NMST (NUM_MASTER),
    .ADDRW(ADDRW),
    .IDXW (IDXW)
  ) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .maskWords  (maskWords),
    .forceWords (forceWords),
    .statusWords(statusWords),
    .mdis       (mdis),
    .anyStat    (anyStat),
    .strobe     (strobe),
    .wrIdx      (wrIdx),
    .regRdata   (regRdata)
  );

  irqAggPath #(
    .NUM_SRC    (NUM_SRC),
    .NMST       (NUM_MASTER),
    .SYNC_STAGES(SYNC_STAGES),
    .IDXW       (IDXW)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .srcIrq     (srcIrq),
    .strobe     (strobe),
    .wrIdx      (wrIdx),
    .wrData     (regWdata),
    .maskWords  (maskWords),
    .forceWords (forceWords),
    .statusWords(statusWords),
    .mdis       (mdis),
    .anyStat    (anyStat),
    .masterIrq  (masterIrq)
  );
endmodule

// File: rtl/irqSteerAggChk.sv
module irqSteerAggChk #(
  parameter int NGRP  = 16,
  parameter int NMST  = 8,
  parameter int ADDRW = 6
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     regWr,
  input logic [ADDRW-1:0]         regAddr,
  input logic [31:0]              regWdata,
  input logic [31:0]              regRdata,
  input logic [NMST-1:0]          masterIrq,
  input logic [NGRP-1:0][31:0]    maskWords,
  input logic [NGRP-1:0][31:0]    forceWords,
  input logic [NGRP-1:0][31:0]    statusWords,
  input logic [NMST-1:0]          mdis,
  input logic                     anyStat
);
  localparam int GPM = NGRP / NMST;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (masterIrq == '0 && regRdata == '0));

  assert_global_covers_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|masterIrq) |-> $past(anyStat));

  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr >= ADDRW'(2*NGRP) && regAddr != ADDRW'(3*NGRP))
    |=> ($stable(maskWords) && $stable(forceWords) && $stable(mdis)));

  assert_hold_state_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> ($stable(maskWords) && $stable(forceWords) && $stable(mdis)));

  for (genvar m = 0; m < NMST; m++) begin : g_mst
    logic ownStat;
    always_comb begin
      ownStat = 1'b0;
      for (int k = 0; k < GPM; k++) ownStat = ownStat | (|statusWords[NGRP-1-(m*GPM+k)]);
    end

    assert_master_from_group_R6: assert property (@(posedge clk) disable iff (!rstN)
      masterIrq[m] |-> $past(ownStat));

    assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
      (regWr && regAddr == ADDRW'(3*NGRP) && regWdata[m]) |=> ##1 !masterIrq[m]);
  end
endmodule

bind irqSteerAgg irqSteerAggChk #(
  .NGRP (NGRP),
  .NMST (NUM_MASTER),
  .ADDRW(ADDRW)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regWr      (regWr),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .regRdata   (regRdata),
  .masterIrq  (masterIrq),
  .maskWords  (maskWords),
  .forceWords (forceWords),
  .statusWords(statusWords),
  .mdis       (mdis),
  .anyStat    (anyStat)
);

// File: tb/sim_irqSteerAgg.sv
`timescale 1ns/1ps
module sim_irqSteerAgg;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [511:0] srcVec = '0;
  logic         regWr = 1'b0;
  logic [5:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic [7:0]   masterIrq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit started = 0;

  always #4 clk = ~clk;

  irqSteerAgg u0 (
    .clk      (clk),
    .rstN     (rstN),
    .srcIrq   (srcVec),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .masterIrq(masterIrq)
  );

  // behavioural reference state
  logic [31:0]  mMask  [16];
  logic [31:0]  mForce [16];
  logic [7:0]   mMdis;
  logic [511:0] mS1, mS2;
  logic [7:0]   expM;
  logic [31:0]  expR;

  function automatic bit srcOn(int n);
    int w = 15 - n / 32;
    int b = n % 32;
    return (mS2[n] & mMask[w][b]) | mForce[w][b];
  endfunction

  function automatic logic [7:0] modelMasters();
    logic [7:0] v = '0;
    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 64; k++)
        if (srcOn(64 * m + k)) v[m] = 1'b1;
    return v & ~mMdis;
  endfunction

  function automatic logic [31:0] modelRead(int a);
    logic [31:0] v = '0;
    if (a < 16) v = mMask[a];
    else if (a < 32) v = mForce[a-16];
    else if (a < 48) begin
      for (int b = 0; b < 32; b++) v[b] = srcOn((15 - (a - 32)) * 32 + b);
    end else if (a == 48) v = {24'h0, mMdis};
    else if (a == 49) begin
      for (int n = 0; n < 512; n++) if (srcOn(n)) v = 32'h1;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) begin mMask[i] = '0; mForce[i] = '0; end
      mMdis = '0; mS1 = '0; mS2 = '0; expM = '0; expR = '0;
    end else begin
      expM = modelMasters();
      expR = modelRead(int'(regAddr));
      if (regWr) begin
        if (regAddr < 16) mMask[regAddr] = regWdata;
        else if (regAddr < 32) mForce[regAddr-16] = regWdata;
        else if (regAddr == 48) mMdis = regWdata[7:0];
      end
      mS2 = mS1;
      mS1 = srcVec;
    end
    started = 1;
    #2;
    if (started && !finished) begin
      total++;
      if (masterIrq !== expM) begin
        bad++;
        $display("FAIL R6 per-cycle master outputs act=%h exp=%h", masterIrq, expM);
      end
      total++;
      if (regRdata !== expR) begin
        bad++;
        $display("FAIL R2 per-cycle read data act=%h exp=%h", regRdata, expR);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(int a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = 6'(a); regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = 6'(a);
    @(negedge clk);
    d = regRdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=done");
    finish();
  end

  initial begin
    logic [31:0] d;
    idle(4);
    rstN = 1'b1;
    // R1 reset state
    check("R1 master outputs after reset", 32'(masterIrq), 32'h0);
    rdReg(0, d);  check("R1 mask word 0 after reset", d, 32'h0);
    rdReg(31, d); check("R1 force word 15 after reset", d, 32'h0);
    rdReg(48, d); check("R1 master-disable after reset", d, 32'h0);

    // R4 mask gating on source 5 (word 15 bit 5, master 0)
    srcVec[5] = 1'b1;
    idle(4);
    check("R4 masked source stays quiet", 32'(masterIrq), 32'h0);
    rdReg(47, d); check("R4 status of masked source", d, 32'h0);
    wrReg(15, 32'h20);
    idle(2);
    check("R4 enabled source reaches master 0", 32'(masterIrq), 32'h01);
    rdReg(47, d); check("R4 status of enabled source", d, 32'h20);

    // R3 reversed index: source 300 -> word 6 bit 12, master 4
    wrReg(6, 32'h1000);
    srcVec[300] = 1'b1;
    idle(4);
    rdReg(38, d); check("R3 status word 6 bit 12", d, 32'h1000);
    check("R3 master 4 from source 300", 32'(masterIrq), 32'h11);

    // R10 whole-word readback
    rdReg(6, d); check("R10 mask word 6 readback", d, 32'h1000);
    wrReg(6, 32'hA5A5_1000);
    rdReg(6, d); check("R10 mask word 6 new pattern", d, 32'hA5A5_1000);
    wrReg(20, 32'h0000_0000);
    rdReg(20, d); check("R10 force word 4 readback", d, 32'h0);

    // R6 latency: source 64 -> word 13 bit 0, master 1
    wrReg(13, 32'hFFFF_FFFF);
    @(negedge clk); srcVec[64] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R6 master 1 not yet after two edges", 32'(masterIrq[1]), 32'h0);
    @(negedge clk);
    check("R6 master 1 set after third edge", 32'(masterIrq[1]), 32'h1);
    srcVec[64] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R6 master 1 held after two edges", 32'(masterIrq[1]), 32'h1);
    @(negedge clk);
    check("R6 master 1 cleared after third edge", 32'(masterIrq[1]), 32'h0);

    // R5 force on masked source 511 -> force word 0 bit 31, master 7
    wrReg(16, 32'h8000_0000);
    @(negedge clk);
    check("R5 forced source reaches master 7", 32'(masterIrq), 32'h91);
    rdReg(32, d); check("R5 status word 0 shows forced bit", d, 32'h8000_0000);

    // R7 master disable
    wrReg(48, 32'h80);
    @(negedge clk);
    check("R7 master 7 disabled others kept", 32'(masterIrq), 32'h11);
    rdReg(48, d); check("R7 master-disable readback", d, 32'h80);
    rdReg(49, d); check("R8 global status with one disabled", d, 32'h1);
    wrReg(48, 32'hFF);
    idle(2);
    check("R7 all masters disabled", 32'(masterIrq), 32'h0);
    rdReg(49, d); check("R8 global status ignores disable", d, 32'h1);

    // R9 writes to read-only and unused addresses
    wrReg(32, 32'h0);
    wrReg(40, 32'hFFFF_FFFF);
    wrReg(49, 32'h0);
    wrReg(60, 32'hFFFF_FFFF);
    rdReg(32, d); check("R9 status word 0 unchanged", d, 32'h8000_0000);
    rdReg(16, d); check("R9 force word 0 unchanged", d, 32'h8000_0000);
    rdReg(0, d);  check("R9 mask word 0 unchanged", d, 32'h0);
    rdReg(8, d);  check("R9 mask word 8 unchanged", d, 32'h0);
    rdReg(48, d); check("R9 master-disable unchanged", d, 32'hFF);
    rdReg(60, d); check("R2 unused address reads zero", d, 32'h0);
    rdReg(55, d); check("R2 unused address 55 reads zero", d, 32'h0);
    rdReg(15, d); check("R2 mask word 15 at address 15", d, 32'h20);

    // random traffic, all masks open, compared every clock
    wrReg(48, 32'h0);
    for (int r = 0; r < 16; r++) wrReg(r, 32'hFFFF_FFFF);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      srcVec[$urandom_range(511, 0)] ^= 1'b1;
      if (i % 50 == 0) begin
        regWr = 1'b1;
        regAddr = 6'($urandom_range(49, 0));
        regWdata = $urandom;
      end else begin
        regWr = 1'b0;
        regAddr = 6'($urandom_range(63, 0));
      end
    end
    @(negedge clk); regWr = 1'b0;
    idle(4);
    finish();
  end
endmodule